// File: doc/BRIEF.md
# I2C Bus Arbitration Detector

This block sits beside a local I2C master's transmitter. It watches the shared open-drain data line and decides whether the local master has lost the bus to another master. On every rising edge of the clock line it compares the bit the local transmitter is putting out with the level actually present on the data line. If the transmitter released the line (drove 1) but the line reads 0, another master is pulling it low, and arbitration is lost.

Two policies control when the sticky lost flag rises. In the per-bit policy the flag rises right after the offending clock edge. In the per-byte policy any mismatch in the nine-bit frame is held in a pending latch, and the flag rises only on the falling clock edge of the ninth bit. Software clears the flag with a strobe, which it must do between the acknowledge of one byte and the start of the next.

An optional release gate drops the data line output enable, which puts the pin in high impedance, in the same cycle the flag rises. Both line inputs pass through a two-flop synchronizer before edge detection.

Top module: `i2c_arb_detect`

## Requirements
- R1: After synchronous reset, `arb_lost` is 0 and `sda_oe` is 1.
- R2: A per-bit mismatch present at the pins when SCL rises sets `arb_lost` on the third rising clock edge after that SCL change. It is still 0 after the second edge.
- R3: A mismatch exists only when `tx_bit` is 1 and the synchronized SDA is 0 at an SCL rising edge. With `tx_bit` 0 the flag never sets, whatever the line level.
- R4: With `mode_byte` 0 (per-bit policy), each mismatch sets `arb_lost` without waiting for the end of the frame.
- R5: With `mode_byte` 1 (per-byte policy), a mismatch in any of bits 0 to 8 of the frame (`bit_idx` 0 is sent first, 8 is the acknowledge bit) sets `arb_lost` only on the SCL falling edge while `bit_idx` is 8. It stays 0 through bits 0 to 7.
- R6: In the per-byte policy, the pending mismatch is discarded at the SCL rising edge of bit 0 of the next frame. A clean frame after a lost frame that was cleared leaves `arb_lost` at 0.
- R7: `arb_lost` is sticky. Once set, it stays 1 until `clr_lost` is asserted.
- R8: `clr_lost` wins over a set in the same cycle. The flag is 0 on the following cycle.
- R9: With `stop_en` 1, `sda_oe` is 0 in the same cycle `arb_lost` is 1. With `stop_en` 0, `sda_oe` stays 1 even while the flag is set.
- R10: SDA changes while SCL is high are not compared. A line drop during the high phase sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| tx_bit | input | 1 | Bit the local transmitter is driving (1 = released) |
| bit_idx | input | IDX_W (4) | Bit position in the 9-bit frame, 0..8 |
| mode_byte | input | 1 | 0 = per-bit flag update, 1 = per-byte (ninth falling edge) |
| stop_en | input | 1 | Release SDA to high impedance on loss |
| clr_lost | input | 1 | Software clear strobe for the lost flag |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| sda_oe | output | 1 | SDA output enable gate (0 = high impedance) |

## Verification
Several rules are checked by assertions on every cycle. In the per-bit policy, a mismatch event is always followed by the flag. In the per-byte policy, the flag only rises right after a ninth-bit falling edge. The flag holds until cleared, a clear always wins, and the release gate follows the flag when enabled. The bench scenarios cover what needs stimulus at the pins: the exact three-cycle latency through the synchronizer, that a line dropping during SCL high is ignored, that a 0 driven locally never counts, and that a frame following a cleared loss starts without a pending mismatch.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

  typedef enum logic {
    ARB_PER_BIT  = 1'b0,
    ARB_PER_BYTE = 1'b1
  } arb_policy_e;

  // Another master wins when we release the line and it reads low.
  function automatic logic line_conflict(input logic driven, input logic seen);
    return driven & ~seen;
  endfunction

  // Next pending state: restart at a frame's first bit, else accumulate.
  function automatic logic pending_next(input logic cur, input logic frame_start,
                                        input logic hit);
    return frame_start ? hit : (cur | hit);
  endfunction

  // Clear dominates any simultaneous set.
  function automatic logic flag_next(input logic cur, input logic set_ev,
                                     input logic clr);
    return clr ? 1'b0 : (cur | set_ev);
  endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/arb_edge.sv
module arb_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/arb_judge.sv
module arb_judge
  import i2c_arb_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int LAST_BIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             tx_bit,
  input  logic [IDX_W-1:0] bit_idx,
  input  arb_policy_e      policy,
  input  logic             clr,
  output logic             lost,
  output logic             mismatch_ev,
  output logic             ninth_fall
);

  localparam logic [IDX_W-1:0] LastIdx  = IDX_W'(LAST_BIT);
  localparam logic [IDX_W-1:0] FirstIdx = '0;

  logic frame_start;
  logic pending_q;
  logic set_ev;
  logic lost_q;

  assign mismatch_ev = scl_rise & line_conflict(tx_bit, sda_s);
  assign frame_start = scl_rise & (bit_idx == FirstIdx);
  assign ninth_fall  = scl_fall & (bit_idx == LastIdx);

  always_ff @(posedge clk) begin
    if (rst) pending_q <= 1'b0;
    else     pending_q <= pending_next(pending_q, frame_start, mismatch_ev);
  end

  always_comb begin
    unique case (policy)
      ARB_PER_BIT:  set_ev = mismatch_ev;
      ARB_PER_BYTE: set_ev = ninth_fall & pending_q;
      default:      set_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) lost_q <= 1'b0;
    else     lost_q <= flag_next(lost_q, set_ev, clr);
  end

  assign lost = lost_q;

  // Per-bit policy: every mismatch shows on the flag one cycle later.
  assert_bit_immediate_R4: assert property (@(posedge clk) disable iff (rst)
    (mismatch_ev && policy == ARB_PER_BIT && !clr) |=> lost);

  // Per-bit policy: the flag rises only because of a mismatch.
  assert_only_on_conflict_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(lost) && $past(policy) == ARB_PER_BIT) |-> $past(mismatch_ev));

  // Per-byte policy: the flag rises only after the ninth falling edge.
  assert_byte_deferred_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(lost) && $past(policy) == ARB_PER_BYTE) |-> $past(ninth_fall));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (lost && !clr) |=> lost);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !lost);

endmodule

// File: rtl/i2c_arb_detect.sv
module i2c_arb_detect
  import i2c_arb_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int LAST_BIT    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             tx_bit,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             mode_byte,
  input  logic             stop_en,
  input  logic             clr_lost,
  output logic             arb_lost,
  output logic             sda_oe
);

  logic [1:0]  lines_s;
  logic        scl_s;
  logic        sda_s;
  logic        scl_rise;
  logic        scl_fall;
  logic        mismatch_ev;
  logic        ninth_fall;
  logic        lost;
  arb_policy_e policy;

  arb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  arb_edge #(.RST_VAL(1'b1)) u_scl_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (scl_s),
    .rise (scl_rise),
    .fall (scl_fall)
  );

  assign policy = mode_byte ? ARB_PER_BYTE : ARB_PER_BIT;

  arb_judge #(.IDX_W(IDX_W), .LAST_BIT(LAST_BIT)) u_judge (
    .clk         (clk),
    .rst         (rst),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .sda_s       (sda_s),
    .tx_bit      (tx_bit),
    .bit_idx     (bit_idx),
    .policy      (policy),
    .clr         (clr_lost),
    .lost        (lost),
    .mismatch_ev (mismatch_ev),
    .ninth_fall  (ninth_fall)
  );

  assign arb_lost = lost;
  assign sda_oe   = ~(stop_en & lost);

  assert_release_on_loss_R9: assert property (@(posedge clk) disable iff (rst)
    (stop_en && $rose(arb_lost)) |-> !sda_oe);

  assert_no_release_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    !stop_en |-> sda_oe);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!arb_lost && sda_oe));

endmodule

// File: tb/sim_i2c_arb_detect.sv
module sim_i2c_arb_detect;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_in = 1'b1;
  logic       sda_in = 1'b1;
  logic       tx_bit = 1'b1;
  logic [3:0] bit_idx = '0;
  logic       mode_byte = 1'b0;
  logic       stop_en = 1'b0;
  logic       clr_lost = 1'b0;
  logic       arb_lost;
  logic       sda_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  i2c_arb_detect u0 (
    .clk (clk), .rst (rst), .scl_in (scl_in), .sda_in (sda_in),
    .tx_bit (tx_bit), .bit_idx (bit_idx), .mode_byte (mode_byte),
    .stop_en (stop_en), .clr_lost (clr_lost),
    .arb_lost (arb_lost), .sda_oe (sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic clear_flag();
    clr_lost = 1'b1;
    tick(1);
    clr_lost = 1'b0;
  endtask

  // One clock-line period for a frame bit, data set while SCL is low.
  task automatic drive_bit(input logic tx, input logic line, input int idx);
    scl_in  = 1'b0;
    bit_idx = 4'(idx);
    tx_bit  = tx;
    sda_in  = line;
    tick(4);
    scl_in = 1'b1;
    tick(4);
    scl_in = 1'b0;
    tick(4);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
    check(arb_lost, 1'b0, "R1 flag after reset");
    check(sda_oe, 1'b1, "R1 oe after reset");
  endtask

  task automatic t_latency();
    mode_byte = 1'b0; stop_en = 1'b0;
    clear_flag();
    scl_in = 1'b0; tx_bit = 1'b1; sda_in = 1'b0; bit_idx = 4'd2;
    tick(4);
    scl_in = 1'b1;
    tick(2);
    check(arb_lost, 1'b0, "R2 flag after two edges");
    tick(1);
    check(arb_lost, 1'b1, "R2 flag after three edges");
    scl_in = 1'b0; sda_in = 1'b1;
    tick(4);
  endtask

  task automatic t_tx_low();
    mode_byte = 1'b0;
    clear_flag();
    drive_bit(1'b0, 1'b1, 0);
    drive_bit(1'b0, 1'b0, 1);
    check(arb_lost, 1'b0, "R3 local zero never conflicts");
    drive_bit(1'b1, 1'b1, 2);
    check(arb_lost, 1'b0, "R3 released and high is no conflict");
  endtask

  task automatic t_bit_mode();
    mode_byte = 1'b0;
    clear_flag();
    drive_bit(1'b1, 1'b1, 0);
    drive_bit(1'b1, 1'b0, 1);
    check(arb_lost, 1'b1, "R4 per-bit set at bit 1");
  endtask

  task automatic t_sticky();
    drive_bit(1'b1, 1'b1, 2);
    drive_bit(1'b0, 1'b0, 3);
    check(arb_lost, 1'b1, "R7 flag holds without clear");
    clear_flag();
    check(arb_lost, 1'b0, "R7 flag clears on strobe");
  endtask

  task automatic t_byte_mode();
    mode_byte = 1'b1;
    clear_flag();
    for (int i = 0; i < 8; i++) drive_bit(1'b1, (i == 3) ? 1'b0 : 1'b1, i);
    check(arb_lost, 1'b0, "R5 no flag before ninth bit");
    drive_bit(1'b1, 1'b0, 8);
    check(arb_lost, 1'b1, "R5 flag after ninth falling edge");
  endtask

  task automatic t_byte_restart();
    mode_byte = 1'b1;
    clear_flag();
    for (int i = 0; i < 9; i++) drive_bit(1'b1, 1'b1, i);
    check(arb_lost, 1'b0, "R6 clean frame after cleared loss");
  endtask

  task automatic t_clear_wins();
    mode_byte = 1'b0;
    clear_flag();
    scl_in = 1'b0; tx_bit = 1'b1; sda_in = 1'b0; bit_idx = 4'd4;
    tick(4);
    scl_in = 1'b1;
    tick(2);
    clr_lost = 1'b1;
    tick(1);
    clr_lost = 1'b0;
    check(arb_lost, 1'b0, "R8 clear beats set");
    tick(3);
    check(arb_lost, 1'b0, "R8 flag stays clear");
    scl_in = 1'b0; sda_in = 1'b1;
    tick(4);
  endtask

  task automatic t_release();
    mode_byte = 1'b0; stop_en = 1'b1;
    clear_flag();
    check(sda_oe, 1'b1, "R9 oe before loss");
    scl_in = 1'b0; tx_bit = 1'b1; sda_in = 1'b0; bit_idx = 4'd5;
    tick(4);
    scl_in = 1'b1;
    tick(3);
    check(arb_lost, 1'b1, "R9 flag at loss cycle");
    check(sda_oe, 1'b0, "R9 oe dropped in loss cycle");
    scl_in = 1'b0; sda_in = 1'b1;
    tick(4);
    stop_en = 1'b0;
    tick(1);
    check(sda_oe, 1'b1, "R9 oe kept with stop disabled");
    clear_flag();
  endtask

  task automatic t_high_phase();
    mode_byte = 1'b0;
    clear_flag();
    scl_in = 1'b0; tx_bit = 1'b1; sda_in = 1'b1; bit_idx = 4'd6;
    tick(4);
    scl_in = 1'b1;
    tick(4);
    sda_in = 1'b0;
    tick(4);
    scl_in = 1'b0;
    tick(4);
    sda_in = 1'b1;
    tick(4);
    check(arb_lost, 1'b0, "R10 drop during SCL high ignored");
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_tx_low();
    t_bit_mode();
    t_sticky();
    t_byte_mode();
    t_byte_restart();
    t_clear_wins();
    t_release();
    t_high_phase();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule